// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This unit holds four machine-level control registers (a scratch word, a trap-vector base, a trap-return PC and a trap cause) for a small single-issue core. It sees every retiring instruction as a 32-bit word, together with its PC and the value of its first source register. It carries out the six CSR access forms (write, set, clear, each with a register or a 5-bit immediate operand) and returns the prior register value for write-back.

The unit also watches for conditions that must divert control flow. These are a misaligned instruction PC, an all-zero or otherwise unsupported system word, a breakpoint word, a misaligned load or store address, and three machine interrupt lines. When one of them is present it records the PC and cause and sends fetch to the trap-vector base. A trap-return word sends fetch to the saved PC.

All outputs are combinational in the current instruction and the registered state. Register updates take effect on the next rising clock edge. The register width is a parameter, `XLEN`, set to 32 or 64.

Top module: `mcsr_trap_unit`

## Requirements
- R1: After reset, the scratch (0x340), vector (0x305), return-PC (0x341) and cause (0x342) registers all read as zero.
- R2: A write form (funct3 001 or 101) stores its operand into the addressed register whatever its rd. It returns the prior value on `rd_value` with `rd_wen` high only when rd (bits 11:7) is nonzero.
- R3: A set form (funct3 010/110) ORs its operand into the register. A clear form (funct3 011/111) clears the register bits where the operand is one. Both return the prior value.
- R4: A set or clear form whose bits 19:15 are zero leaves the register unchanged, and this holds for both the register and immediate variants.
- R5: The immediate forms (funct3 bit 2 set) use bits 19:15 of the word, zero-extended to XLEN, as the operand instead of `rs1_value`.
- R6: Bits 1:0 of the vector register always read zero, whatever value is written to it.
- R7: A CSR form that addresses any register other than the four listed in R1 raises cause code 2. It writes no register other than the trap-return PC and the cause, and it asserts no `rd_wen`.
- R8: The all-zero word raises code 2. Opcode 1110011 with funct3 000 or 100 raises code 2, except for the breakpoint word 0x00100073, which raises code 3, and the return word 0x30200073.
- R9: A PC with nonzero bits 1:0 raises code 0, and this takes precedence over any decode result. A load (opcode 0000011) or store (opcode 0100011) whose address `rs1_value`+sign-extended offset is not aligned to 2^funct3[1:0] bytes raises code 4 or code 6.
- R10: With `instr_valid` high, `irq_ext`, `irq_soft` and `irq_timer` raise codes 11, 3 and 7, in that priority order, ahead of every exception. The cause register then has bit XLEN-1 set, and exceptions leave that bit clear.
- R11: On a trap, `trap_taken` and `redirect_valid` are high and `redirect_pc` equals the vector register. On the next edge the return-PC register holds `instr_pc` and the cause register holds the new cause. Any CSR write and any `rd_wen` from the same instruction are suppressed.
- R12: The return word raises `redirect_valid` with `redirect_pc` equal to the current return-PC register, including a value that software has just written, and it does not raise `trap_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_word | input | 32 | Instruction word |
| instr_pc | input | XLEN | PC of the presented instruction |
| rs1_value | input | XLEN | Value of the first source register |
| irq_soft | input | 1 | Machine software interrupt request |
| irq_timer | input | 1 | Machine timer interrupt request |
| irq_ext | input | 1 | Machine external interrupt request |
| rd_wen | output | 1 | Write the destination register |
| rd_addr | output | 5 | Destination register index |
| rd_value | output | XLEN | Prior CSR value for write-back |
| trap_taken | output | 1 | A trap is taken this cycle |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | XLEN | Restart address |

## Verification
An interrupt request can arrive in the same cycle as a CSR write. In that case the trap capture and the register update compete for the same edge. The bench raises an interrupt line while it presents a write to the scratch register. It expects a trap with no write-back, and it reads the scratch register again to confirm that the earlier value survived. It also checks that a return-PC rewrite followed at once by a return word steers fetch to the new value.

// File: rtl/mcsr_pkg.sv
`timescale 1ns/1ps
package mcsr_pkg;

    localparam logic [6:0]  OPC_SYSTEM  = 7'b1110011;
    localparam logic [6:0]  OPC_LOAD    = 7'b0000011;
    localparam logic [6:0]  OPC_STORE   = 7'b0100011;
    localparam logic [31:0] WORD_BREAK  = 32'h0010_0073;
    localparam logic [31:0] WORD_RETURN = 32'h3020_0073;

    localparam logic [11:0] ADDR_SCRATCH = 12'h340;
    localparam logic [11:0] ADDR_VECTOR  = 12'h305;
    localparam logic [11:0] ADDR_RETPC   = 12'h341;
    localparam logic [11:0] ADDR_CAUSE   = 12'h342;

    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] CODE_PC_MIS  = 4'd0;
    localparam logic [CODE_W-1:0] CODE_ILLEGAL = 4'd2;
    localparam logic [CODE_W-1:0] CODE_BREAK   = 4'd3;
    localparam logic [CODE_W-1:0] CODE_LD_MIS  = 4'd4;
    localparam logic [CODE_W-1:0] CODE_ST_MIS  = 4'd6;
    localparam logic [CODE_W-1:0] CODE_IRQ_SW  = 4'd3;
    localparam logic [CODE_W-1:0] CODE_IRQ_TMR = 4'd7;
    localparam logic [CODE_W-1:0] CODE_IRQ_EXT = 4'd11;

    // encoding matches funct3[1:0] of the CSR forms
    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_SET   = 2'd2,
        KIND_CLEAR = 2'd3
    } csr_kind_e;

    typedef struct packed {
        logic        is_csr;
        csr_kind_e   kind;
        logic        use_imm;
        logic [11:0] csr_addr;
        logic [4:0]  rd;
        logic [4:0]  src;
        logic        is_break;
        logic        is_return;
        logic        is_mem;
        logic        is_store;
        logic [1:0]  mem_size;
        logic [2:0]  mem_off_lo;
        logic        illegal;
    } decode_t;

endpackage

// File: rtl/mcsr_decode.sv
`timescale 1ns/1ps
module mcsr_decode
    import mcsr_pkg::*;
(
    input  logic [31:0] word,
    output decode_t     dec
);
    logic [6:0] opc;
    logic [2:0] f3;

    always_comb begin
        opc = word[6:0];
        f3  = word[14:12];
        dec = '0;
        dec.csr_addr = word[31:20];
        dec.rd       = word[11:7];
        dec.src      = word[19:15];
        dec.mem_size = f3[1:0];
        if (word == 32'd0) begin
            dec.illegal = 1'b1;
        end else if (opc == OPC_SYSTEM) begin
            if (f3 == 3'b000) begin
                if (word == WORD_BREAK)       dec.is_break  = 1'b1;
                else if (word == WORD_RETURN) dec.is_return = 1'b1;
                else                          dec.illegal   = 1'b1;
            end else if (f3 == 3'b100) begin
                dec.illegal = 1'b1;
            end else begin
                dec.is_csr  = 1'b1;
                dec.kind    = csr_kind_e'(f3[1:0]);
                dec.use_imm = f3[2];
            end
        end else if (opc == OPC_LOAD) begin
            dec.is_mem     = 1'b1;
            dec.mem_off_lo = word[22:20];
        end else if (opc == OPC_STORE) begin
            dec.is_mem     = 1'b1;
            dec.is_store   = 1'b1;
            dec.mem_off_lo = word[9:7];
        end
    end
endmodule

// File: rtl/mcsr_align_chk.sv
`timescale 1ns/1ps
module mcsr_align_chk (
    input  logic [2:0] base_lo,
    input  logic [2:0] off_lo,
    input  logic [1:0] size,
    output logic       misaligned
);
    // only the low address bits decide alignment, so a 3-bit sum suffices
    logic [2:0] eff_lo;

    always_comb begin
        eff_lo = base_lo + off_lo;
        case (size)
            2'd0:    misaligned = 1'b0;
            2'd1:    misaligned = eff_lo[0];
            2'd2:    misaligned = |eff_lo[1:0];
            default: misaligned = |eff_lo;
        endcase
    end
endmodule

// File: rtl/mcsr_trap_sel.sv
`timescale 1ns/1ps
module mcsr_trap_sel
    import mcsr_pkg::*;
(
    input  logic              valid,
    input  logic              irq_soft,
    input  logic              irq_timer,
    input  logic              irq_ext,
    input  logic              pc_mis,
    input  logic              illegal,
    input  logic              brk,
    input  logic              ld_mis,
    input  logic              st_mis,
    output logic              take,
    output logic              is_irq,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        take   = 1'b0;
        is_irq = 1'b0;
        code   = '0;
        if (valid) begin
            take = 1'b1;
            if (irq_ext)        begin is_irq = 1'b1; code = CODE_IRQ_EXT; end
            else if (irq_soft)  begin is_irq = 1'b1; code = CODE_IRQ_SW;  end
            else if (irq_timer) begin is_irq = 1'b1; code = CODE_IRQ_TMR; end
            else if (pc_mis)    code = CODE_PC_MIS;
            else if (illegal)   code = CODE_ILLEGAL;
            else if (brk)       code = CODE_BREAK;
            else if (ld_mis)    code = CODE_LD_MIS;
            else if (st_mis)    code = CODE_ST_MIS;
            else                take = 1'b0;
        end
    end
endmodule

// File: rtl/mcsr_trap_unit.sv
`timescale 1ns/1ps
module mcsr_trap_unit
    import mcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [31:0]     instr_word,
    input  logic [XLEN-1:0] instr_pc,
    input  logic [XLEN-1:0] rs1_value,
    input  logic            irq_soft,
    input  logic            irq_timer,
    input  logic            irq_ext,
    output logic            rd_wen,
    output logic [4:0]      rd_addr,
    output logic [XLEN-1:0] rd_value,
    output logic            trap_taken,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);
    localparam logic [XLEN-1:0] VEC_MASK = ~{{(XLEN-2){1'b0}}, 2'b11};

    typedef struct packed {
        logic [XLEN-1:0] scratch;
        logic [XLEN-1:0] tvec;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
    } csr_state_t;

    csr_state_t st_d, st_q;
    decode_t    dec;

    logic              mem_mis;
    logic              take, take_irq;
    logic [CODE_W-1:0] take_code;
    logic              known;
    logic [XLEN-1:0]   old_val, operand, new_val;
    logic              do_write;

    mcsr_decode i_decode (
        .word (instr_word),
        .dec  (dec)
    );

    mcsr_align_chk i_align (
        .base_lo    (rs1_value[2:0]),
        .off_lo     (dec.mem_off_lo),
        .size       (dec.mem_size),
        .misaligned (mem_mis)
    );

    mcsr_trap_sel i_sel (
        .valid     (instr_valid),
        .irq_soft  (irq_soft),
        .irq_timer (irq_timer),
        .irq_ext   (irq_ext),
        .pc_mis    (|instr_pc[1:0]),
        .illegal   (dec.illegal | (dec.is_csr & ~known)),
        .brk       (dec.is_break),
        .ld_mis    (dec.is_mem & ~dec.is_store & mem_mis),
        .st_mis    (dec.is_mem &  dec.is_store & mem_mis),
        .take      (take),
        .is_irq    (take_irq),
        .code      (take_code)
    );

    always_comb begin
        known = 1'b1;
        case (dec.csr_addr)
            ADDR_SCRATCH: old_val = st_q.scratch;
            ADDR_VECTOR:  old_val = st_q.tvec;
            ADDR_RETPC:   old_val = st_q.epc;
            ADDR_CAUSE:   old_val = st_q.cause;
            default: begin
                old_val = '0;
                known   = 1'b0;
            end
        endcase

        operand = dec.use_imm ? {{(XLEN-5){1'b0}}, dec.src} : rs1_value;
        case (dec.kind)
            KIND_WRITE: new_val = operand;
            KIND_SET:   new_val = old_val | operand;
            KIND_CLEAR: new_val = old_val & ~operand;
            default:    new_val = old_val;
        endcase

        do_write = instr_valid & dec.is_csr & known & ~take &
                   ((dec.kind == KIND_WRITE) | (dec.src != 5'd0));

        st_d = st_q;
        if (do_write) begin
            case (dec.csr_addr)
                ADDR_SCRATCH: st_d.scratch = new_val;
                ADDR_VECTOR:  st_d.tvec    = new_val & VEC_MASK;
                ADDR_RETPC:   st_d.epc     = new_val;
                ADDR_CAUSE:   st_d.cause   = new_val;
                default:      st_d.scratch = st_q.scratch;
            endcase
        end
        if (take) begin
            st_d.epc               = instr_pc;
            st_d.cause             = '0;
            st_d.cause[XLEN-1]     = take_irq;
            st_d.cause[CODE_W-1:0] = take_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        trap_taken     = take;
        rd_wen         = instr_valid & dec.is_csr & known & ~take & (dec.rd != 5'd0);
        rd_addr        = dec.rd;
        rd_value       = old_val;
        redirect_valid = take | (instr_valid & dec.is_return);
        redirect_pc    = take ? st_q.tvec : st_q.epc;
    end
endmodule

// File: rtl/mcsr_trap_unit_chk.sv
`timescale 1ns/1ps
module mcsr_trap_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic            irq_soft,
    input logic            irq_timer,
    input logic            irq_ext,
    input logic            trap_taken,
    input logic            redirect_valid,
    input logic            rd_wen,
    input logic [XLEN-1:0] instr_pc,
    input logic [XLEN-1:0] redirect_pc,
    input logic [XLEN-1:0] tvec_q,
    input logic [XLEN-1:0] epc_q,
    input logic            cause_msb
);
    // R11
    trap_epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> epc_q == $past(instr_pc));

    // R11
    trap_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (redirect_valid && redirect_pc == tvec_q));

    // R11
    trap_no_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> !rd_wen);

    // R6
    vector_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tvec_q[1:0] == 2'b00);

    // R10
    irq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && (irq_soft || irq_timer || irq_ext)) |-> trap_taken);

    // R10
    irq_cause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && (irq_soft || irq_timer || irq_ext)) |=> cause_msb);

    // R10
    exc_cause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && !(irq_soft || irq_timer || irq_ext)) |=> !cause_msb);
endmodule

bind mcsr_trap_unit mcsr_trap_unit_chk #(.XLEN(XLEN)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .instr_valid    (instr_valid),
    .irq_soft       (irq_soft),
    .irq_timer      (irq_timer),
    .irq_ext        (irq_ext),
    .trap_taken     (trap_taken),
    .redirect_valid (redirect_valid),
    .rd_wen         (rd_wen),
    .instr_pc       (instr_pc),
    .redirect_pc    (redirect_pc),
    .tvec_q         (st_q.tvec),
    .epc_q          (st_q.epc),
    .cause_msb      (st_q.cause[XLEN-1])
);

// File: tb/test_mcsr_trap_unit.sv
`timescale 1ns/1ps
module test_mcsr_trap_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [31:0]  instr_word = '0;
    logic [W-1:0] instr_pc = '0;
    logic [W-1:0] rs1_value = '0;
    logic         irq_soft = 1'b0, irq_timer = 1'b0, irq_ext = 1'b0;
    logic         rd_wen, trap_taken, redirect_valid;
    logic [4:0]   rd_addr;
    logic [W-1:0] rd_value, redirect_pc;

    int n_vec = 0;
    int n_bad = 0;

    logic [W-1:0] m_scratch = '0, m_tvec = '0, m_epc = '0, m_cause = '0;

    always #4ns clk = ~clk;

    mcsr_trap_unit #(.XLEN(W)) i_mcsr_trap_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_word(instr_word), .instr_pc(instr_pc), .rs1_value(rs1_value),
        .irq_soft(irq_soft), .irq_timer(irq_timer), .irq_ext(irq_ext),
        .rd_wen(rd_wen), .rd_addr(rd_addr), .rd_value(rd_value),
        .trap_taken(trap_taken), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc)
    );

    function automatic logic [31:0] csr_op(input logic [2:0] f3, input logic [11:0] a,
                                           input logic [4:0] src, input logic [4:0] rd);
        return {a, src, f3, rd, 7'b1110011};
    endfunction

    function automatic logic [31:0] ld_op(input logic [2:0] f3, input logic [11:0] off);
        return {off, 5'd2, f3, 5'd9, 7'b0000011};
    endfunction

    function automatic logic [31:0] st_op(input logic [2:0] f3, input logic [11:0] off);
        return {off[11:5], 5'd8, 5'd2, f3, off[4:0], 7'b0100011};
    endfunction

    task automatic step(input string tag, input logic v, input logic [31:0] w,
                        input logic [W-1:0] pc, input logic [W-1:0] r1v,
                        input logic [2:0] irq);
        logic         e_trap, e_intr, e_wen, e_rv, known, mis, bad;
        logic [3:0]   e_code;
        logic [W-1:0] e_rdv, e_rpc, old, opnd, nv, addr;
        logic [11:0]  imm;
        @(negedge clk);
        instr_valid = v; instr_word = w; instr_pc = pc; rs1_value = r1v;
        irq_soft = irq[0]; irq_timer = irq[1]; irq_ext = irq[2];
        e_trap = 0; e_intr = 0; e_wen = 0; e_rv = 0; e_code = 0;
        e_rdv = '0; e_rpc = '0; old = '0;
        if (v) begin
            if (irq[2])      begin e_trap = 1; e_intr = 1; e_code = 11; end
            else if (irq[0]) begin e_trap = 1; e_intr = 1; e_code = 3;  end
            else if (irq[1]) begin e_trap = 1; e_intr = 1; e_code = 7;  end
            else if (pc[1:0] != 0) begin e_trap = 1; e_code = 0; end
            else if (w == 0) begin e_trap = 1; e_code = 2; end
            else if (w[6:0] == 7'h73) begin
                if (w[14:12] == 0) begin
                    if (w == 32'h00100073) begin e_trap = 1; e_code = 3; end
                    else if (w == 32'h30200073) begin e_rv = 1; e_rpc = m_epc; end
                    else begin e_trap = 1; e_code = 2; end
                end else if (w[14:12] == 4) begin
                    e_trap = 1; e_code = 2;
                end else begin
                    known = 1;
                    case (w[31:20])
                        12'h340: old = m_scratch;
                        12'h305: old = m_tvec;
                        12'h341: old = m_epc;
                        12'h342: old = m_cause;
                        default: known = 0;
                    endcase
                    if (!known) begin
                        e_trap = 1; e_code = 2;
                    end else begin
                        opnd = w[14] ? W'(w[19:15]) : r1v;
                        if (w[13:12] == 1)      nv = opnd;
                        else if (w[13:12] == 2) nv = old | opnd;
                        else                    nv = old & ~opnd;
                        e_wen = (w[11:7] != 0);
                        e_rdv = old;
                        if (w[13:12] == 1 || w[19:15] != 0) begin
                            case (w[31:20])
                                12'h340: m_scratch = nv;
                                12'h305: m_tvec    = nv & ~W'(3);
                                12'h341: m_epc     = nv;
                                default: m_cause   = nv;
                            endcase
                        end
                    end
                end
            end else if (w[6:0] == 7'h03 || w[6:0] == 7'h23) begin
                imm  = (w[6:0] == 7'h23) ? {w[31:25], w[11:7]} : w[31:20];
                addr = r1v + {{(W-12){imm[11]}}, imm};
                mis  = (w[13:12] == 1 && addr[0]) || (w[13:12] == 2 && addr[1:0] != 0) ||
                       (w[13:12] == 3 && addr[2:0] != 0);
                if (mis) begin e_trap = 1; e_code = (w[6:0] == 7'h23) ? 4'd6 : 4'd4; end
            end
        end
        if (e_trap) begin
            e_rv = 1; e_rpc = m_tvec; e_wen = 0;
            m_epc = pc;
            m_cause = '0; m_cause[W-1] = e_intr; m_cause[3:0] = e_code;
        end
        #3ns;
        n_vec++;
        bad = 0;
        if (trap_taken !== e_trap) begin
            $display("FAIL %s trap_taken got %b exp %b", tag, trap_taken, e_trap); bad = 1; end
        if (redirect_valid !== e_rv) begin
            $display("FAIL %s redirect_valid got %b exp %b", tag, redirect_valid, e_rv); bad = 1; end
        if (e_rv && redirect_pc !== e_rpc) begin
            $display("FAIL %s redirect_pc got %h exp %h", tag, redirect_pc, e_rpc); bad = 1; end
        if (rd_wen !== e_wen) begin
            $display("FAIL %s rd_wen got %b exp %b", tag, rd_wen, e_wen); bad = 1; end
        if (e_wen && (rd_value !== e_rdv || rd_addr !== w[11:7])) begin
            $display("FAIL %s rd got x%0d=%h exp x%0d=%h", tag, rd_addr, rd_value, w[11:7], e_rdv);
            bad = 1;
        end
        if (bad) n_bad++;
    endtask

    // read a CSR without side effects (set form, source x0)
    task automatic rd_csr(input string tag, input logic [11:0] a);
        step(tag, 1, csr_op(3'b010, a, 5'd0, 5'd5), 32'h100, 32'hFFFF_FFFF, 3'b000);
    endtask

    localparam logic [31:0] NOP = 32'h0000_0013;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1 idle", 0, NOP, 0, 0, 3'b000);
        // R1 reset values
        rd_csr("R1 scratch", 12'h340);
        rd_csr("R1 vector", 12'h305);
        rd_csr("R1 retpc", 12'h341);
        rd_csr("R1 cause", 12'h342);
        // R2 write form
        step("R2 write", 1, csr_op(3'b001, 12'h340, 5'd3, 5'd6), 32'h100, 32'hA5A5_0F0F, 3'b000);
        step("R2 write again", 1, csr_op(3'b001, 12'h340, 5'd3, 5'd7), 32'h104, 32'h0000_1234, 3'b000);
        step("R2 write rd0", 1, csr_op(3'b001, 12'h340, 5'd3, 5'd0), 32'h108, 32'h0F0F_0000, 3'b000);
        rd_csr("R2 readback", 12'h340);
        // R3 set / clear
        step("R3 set", 1, csr_op(3'b010, 12'h340, 5'd4, 5'd6), 32'h10C, 32'h0000_00F0, 3'b000);
        step("R3 clear", 1, csr_op(3'b011, 12'h340, 5'd4, 5'd6), 32'h110, 32'h0F00_0030, 3'b000);
        rd_csr("R3 readback", 12'h340);
        // R4 suppressed write
        step("R4 set x0", 1, csr_op(3'b010, 12'h340, 5'd0, 5'd6), 32'h114, 32'hFFFF_FFFF, 3'b000);
        step("R4 clear x0", 1, csr_op(3'b011, 12'h340, 5'd0, 5'd6), 32'h118, 32'hFFFF_FFFF, 3'b000);
        step("R4 clri 0", 1, csr_op(3'b111, 12'h340, 5'd0, 5'd6), 32'h11C, 32'hFFFF_FFFF, 3'b000);
        rd_csr("R4 readback", 12'h340);
        // R5 immediate forms
        step("R5 wri", 1, csr_op(3'b101, 12'h340, 5'h15, 5'd6), 32'h120, 32'hFFFF_FFFF, 3'b000);
        step("R5 seti", 1, csr_op(3'b110, 12'h340, 5'h1F, 5'd6), 32'h124, 32'h0, 3'b000);
        step("R5 clri", 1, csr_op(3'b111, 12'h340, 5'h03, 5'd6), 32'h128, 32'h0, 3'b000);
        rd_csr("R5 readback", 12'h340);
        // R6 vector low bits
        step("R6 vec write", 1, csr_op(3'b001, 12'h305, 5'd3, 5'd0), 32'h12C, 32'h8000_0107, 3'b000);
        rd_csr("R6 vec read", 12'h305);
        step("R6 vec seti", 1, csr_op(3'b110, 12'h305, 5'h03, 5'd6), 32'h130, 32'h0, 3'b000);
        // R7 unknown address
        step("R7 unknown", 1, csr_op(3'b001, 12'h7C0, 5'd3, 5'd6), 32'h134, 32'hDEAD_BEEF, 3'b000);
        rd_csr("R7 cause", 12'h342);
        rd_csr("R7 retpc", 12'h341);
        rd_csr("R7 scratch", 12'h340);
        // R8 illegal and breakpoint
        step("R8 zero word", 1, 32'h0, 32'h200, 32'h0, 3'b000);
        rd_csr("R8 cause zero", 12'h342);
        step("R8 break", 1, 32'h0010_0073, 32'h204, 32'h0, 3'b000);
        rd_csr("R8 cause break", 12'h342);
        step("R8 sys f3 0", 1, 32'h0000_0073, 32'h208, 32'h0, 3'b000);
        step("R8 sys f3 4", 1, csr_op(3'b100, 12'h340, 5'd1, 5'd6), 32'h20C, 32'h0, 3'b000);
        step("R8 plain op", 1, NOP, 32'h210, 32'h0, 3'b000);
        // R9 alignment
        step("R9 lw mis", 1, ld_op(3'b010, 12'd3), 32'h300, 32'h1000, 3'b000);
        rd_csr("R9 cause ld", 12'h342);
        step("R9 lw ok", 1, ld_op(3'b010, 12'd4), 32'h304, 32'h1000, 3'b000);
        step("R9 lw neg ok", 1, ld_op(3'b010, 12'hFFC), 32'h308, 32'h1004, 3'b000);
        step("R9 sw mis", 1, st_op(3'b010, 12'd2), 32'h30C, 32'h1000, 3'b000);
        rd_csr("R9 cause st", 12'h342);
        step("R9 sh mis", 1, st_op(3'b001, 12'd1), 32'h310, 32'h1000, 3'b000);
        step("R9 lh ok", 1, ld_op(3'b001, 12'd2), 32'h314, 32'h1000, 3'b000);
        step("R9 lb any", 1, ld_op(3'b000, 12'd3), 32'h318, 32'h1000, 3'b000);
        step("R9 base mis", 1, ld_op(3'b010, 12'd0), 32'h31C, 32'h1001, 3'b000);
        step("R9 pc mis", 1, 32'h0010_0073, 32'h322, 32'h0, 3'b000);
        rd_csr("R9 cause pc", 12'h342);
        rd_csr("R9 retpc", 12'h341);
        // R10 interrupts
        step("R10 timer", 1, NOP, 32'h400, 32'h0, 3'b010);
        rd_csr("R10 cause timer", 12'h342);
        step("R10 ext wins", 1, NOP, 32'h404, 32'h0, 3'b111);
        rd_csr("R10 cause ext", 12'h342);
        step("R10 soft over timer", 1, 32'h0, 32'h408, 32'h0, 3'b011);
        rd_csr("R10 cause soft", 12'h342);
        step("R10 no valid", 0, NOP, 32'h40C, 32'h0, 3'b111);
        // R11 trap beats CSR write in the same cycle
        step("R11 irq with write", 1, csr_op(3'b001, 12'h340, 5'd3, 5'd6), 32'h500, 32'h7777_7777, 3'b001);
        rd_csr("R11 scratch kept", 12'h340);
        rd_csr("R11 retpc", 12'h341);
        step("R11 irq with vecw", 1, csr_op(3'b001, 12'h305, 5'd3, 5'd0), 32'h504, 32'h0000_4000, 3'b100);
        rd_csr("R11 vec kept", 12'h305);
        // R12 return
        step("R12 retpc write", 1, csr_op(3'b001, 12'h341, 5'd3, 5'd0), 32'h600, 32'h0000_2000, 3'b000);
        step("R12 return", 1, 32'h3020_0073, 32'h604, 32'h0, 3'b000);
        step("R12 return again", 1, 32'h3020_0073, 32'h608, 32'h0, 3'b000);
        step("R12 idle", 0, NOP, 32'h0, 32'h0, 3'b000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8ns * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule